// File: doc/BRIEF.md
# Reservation Station with Tag Wakeup and Oldest-First Select

This block is a small scheduling pool that sits between the rename stage and one functional unit. A renamed instruction enters the pool only while a slot is empty. It brings an opcode, a destination tag and two source operands. Each operand arrives either as a finished value or as the tag of the instruction that will produce it. The pool holds waiting instructions so that younger independent work can reach the unit ahead of them.

Each cycle, every operand that is still waiting compares its stored tag against the tag on the shared result bus. On a qualified match the operand takes the bus value. An entry becomes eligible once both of its operands hold values. In each cycle the pool picks one eligible entry, the oldest one, and presents it on the dispatch outputs. The dispatch-valid output also acts as the request to the unit. The chosen entry is released at the clock edge that ends its dispatch cycle.

Top module: `rsPool`

## Requirements
- R1: `insReady` is high exactly when at least one of the 4 entries is empty. An insert presented while `insReady` is low is dropped and never dispatches.
- R2: An instruction inserted with both operands marked ready at a clock edge is presented on the dispatch outputs in the cycle after that edge, with its opcode, both values and its destination tag.
- R3: A held operand that is waiting on tag T takes `cdbVal` at an edge where `cdbValid` is 1 and `cdbTag` equals T. With `cdbValid` at 0 a matching tag has no effect.
- R4: An operand inserted as waiting on tag T, at the same edge that the bus broadcasts T with `cdbValid` 1, holds the broadcast value at once.
- R5: `dispValid` is high only when some entry has both operands ready. At most one entry dispatches per cycle.
- R6: A younger entry with both operands ready dispatches ahead of an older entry that is still waiting.
- R7: When several entries are eligible in the same cycle, the one inserted earliest dispatches first. The rest follow in insertion order, one per cycle.
- R8: A dispatched entry stays occupied during its dispatch cycle. It is empty from the next cycle on, when it can take a new insert.
- R9: After reset all entries are empty, `insReady` is 1 and `dispValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | Insert request from rename |
| insReady | output | 1 | An empty entry exists |
| insOp | input | 4 | Operation code |
| insDst | input | 3 | Destination tag of the instruction |
| insARdy | input | 1 | Source A holds a value |
| insATag | input | 3 | Producer tag of source A |
| insAVal | input | 16 | Value of source A |
| insBRdy | input | 1 | Source B holds a value |
| insBTag | input | 3 | Producer tag of source B |
| insBVal | input | 16 | Value of source B |
| cdbValid | input | 1 | Result bus carries a broadcast |
| cdbTag | input | 3 | Tag of the broadcast result |
| cdbVal | input | 16 | Value of the broadcast result |
| dispValid | output | 1 | Dispatch request to the unit |
| dispOp | output | 4 | Dispatched operation code |
| dispA | output | 16 | Dispatched source A value |
| dispB | output | 16 | Dispatched source B value |
| dispDst | output | 3 | Dispatched destination tag |

## Verification
The stimulus includes an instruction with both operands ready, which shows the direct insert-to-dispatch path. A dependent instruction is followed by an independent one, which separates dataflow order from program order. A broadcast with the valid bit low tests that the bus qualifier matters. Two or four entries waiting on one tag and woken together show whether the age-based select holds insertion order. An insert that coincides with its producer's broadcast tests same-cycle capture. A full pool with a dropped insert, followed by a refill into the slot that was just freed, pins down the exact cycle in which an entry becomes available again.

// File: rtl/rsPkg.sv
package rsPkg;
  parameter int unsigned RS_DEPTH = 4;
  parameter int unsigned TAG_W    = 3;
  parameter int unsigned DATA_W   = 16;
  parameter int unsigned OP_W     = 4;
  localparam int unsigned IDX_W   = (RS_DEPTH > 1) ? $clog2(RS_DEPTH) : 1;

  typedef logic [TAG_W-1:0]    tag_t;
  typedef logic [DATA_W-1:0]   data_t;
  typedef logic [OP_W-1:0]     op_t;
  typedef logic [RS_DEPTH-1:0] entMask_t;
  typedef logic [IDX_W-1:0]    age_t;

  // strobes from control to datapath
  typedef struct packed {
    entMask_t insSel;   // one-hot slot written this edge
    entMask_t dispSel;  // one-hot slot dispatched this cycle
  } ctrlStrobe_t;
endpackage

// File: rtl/rsOperand.sv
module rsOperand
  import rsPkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  load,
  input  logic  insRdy,
  input  tag_t  insTag,
  input  data_t insVal,
  input  logic  cdbValid,
  input  tag_t  cdbTag,
  input  data_t cdbVal,
  output logic  rdy,
  output data_t val
);
  logic  rdyQ;
  tag_t  tagQ;
  data_t valQ;
  logic  hitIns, hitHeld;

  assign hitIns  = cdbValid && (cdbTag == insTag);
  assign hitHeld = cdbValid && (cdbTag == tagQ) && !rdyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdyQ <= 1'b0;
      tagQ <= '0;
      valQ <= '0;
    end else if (load) begin
      tagQ <= insTag;
      rdyQ <= insRdy || hitIns;
      valQ <= (!insRdy && hitIns) ? cdbVal : insVal;
    end else if (hitHeld) begin
      rdyQ <= 1'b1;
      valQ <= cdbVal;
    end
  end

  assign rdy = rdyQ;
  assign val = valQ;
endmodule

// File: rtl/rsData.sv
module rsData
  import rsPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobes,
  input  op_t         insOp,
  input  tag_t        insDst,
  input  logic        insARdy,
  input  tag_t        insATag,
  input  data_t       insAVal,
  input  logic        insBRdy,
  input  tag_t        insBTag,
  input  data_t       insBVal,
  input  logic        cdbValid,
  input  tag_t        cdbTag,
  input  data_t       cdbVal,
  output entMask_t    entRdy,
  output logic        dispValid,
  output op_t         dispOp,
  output data_t       dispA,
  output data_t       dispB,
  output tag_t        dispDst
);
  op_t   opQ  [RS_DEPTH];
  tag_t  dstQ [RS_DEPTH];
  data_t aVal [RS_DEPTH];
  data_t bVal [RS_DEPTH];
  logic  [RS_DEPTH-1:0] aRdy, bRdy;

  for (genvar e = 0; e < RS_DEPTH; e++) begin : gEnt
    always_ff @(posedge clk) begin
      if (!rstN) begin
        opQ[e]  <= '0;
        dstQ[e] <= '0;
      end else if (strobes.insSel[e]) begin
        opQ[e]  <= insOp;
        dstQ[e] <= insDst;
      end
    end

    rsOperand uSrcA (
      .clk(clk), .rstN(rstN), .load(strobes.insSel[e]),
      .insRdy(insARdy), .insTag(insATag), .insVal(insAVal),
      .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbVal(cdbVal),
      .rdy(aRdy[e]), .val(aVal[e])
    );

    rsOperand uSrcB (
      .clk(clk), .rstN(rstN), .load(strobes.insSel[e]),
      .insRdy(insBRdy), .insTag(insBTag), .insVal(insBVal),
      .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbVal(cdbVal),
      .rdy(bRdy[e]), .val(bVal[e])
    );
  end

  assign entRdy = aRdy & bRdy;

  // and-or mux driven by the one-hot dispatch select
  always_comb begin
    dispValid = 1'b0;
    dispOp    = '0;
    dispA     = '0;
    dispB     = '0;
    dispDst   = '0;
    for (int e = 0; e < RS_DEPTH; e++) begin
      if (strobes.dispSel[e]) begin
        dispValid = 1'b1;
        dispOp    = dispOp  | opQ[e];
        dispA     = dispA   | aVal[e];
        dispB     = dispB   | bVal[e];
        dispDst   = dispDst | dstQ[e];
      end
    end
  end
endmodule

// File: rtl/rsCtrl.sv
module rsCtrl
  import rsPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        insValid,
  input  entMask_t    entRdy,
  output logic        insReady,
  output entMask_t    validVec,
  output ctrlStrobe_t strobes
);
  entMask_t validQ;
  age_t     ageQ [RS_DEPTH];   // count of younger occupied entries
  entMask_t eligible;
  logic     slotFound, anyPick;
  age_t     pickAge;
  logic     insAny;

  assign insReady = |(~validQ);
  assign eligible = validQ & entRdy;
  assign validVec = validQ;

  // lowest empty slot takes the insert
  always_comb begin
    strobes.insSel = '0;
    slotFound = 1'b0;
    for (int e = 0; e < RS_DEPTH; e++) begin
      if (!slotFound && !validQ[e]) begin
        strobes.insSel[e] = insValid;
        slotFound = 1'b1;
      end
    end
  end

  // oldest eligible entry wins
  always_comb begin
    strobes.dispSel = '0;
    anyPick = 1'b0;
    pickAge = '0;
    for (int e = 0; e < RS_DEPTH; e++) begin
      if (eligible[e] && (!anyPick || ageQ[e] > pickAge)) begin
        anyPick = 1'b1;
        pickAge = ageQ[e];
        strobes.dispSel = '0;
        strobes.dispSel[e] = 1'b1;
      end
    end
  end

  assign insAny = |strobes.insSel;

  for (genvar e = 0; e < RS_DEPTH; e++) begin : gAge
    logic olderGone;
    assign olderGone = anyPick && (ageQ[e] > pickAge);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[e] <= 1'b0;
        ageQ[e]   <= '0;
      end else if (strobes.insSel[e]) begin
        validQ[e] <= 1'b1;
        ageQ[e]   <= '0;
      end else if (strobes.dispSel[e]) begin
        validQ[e] <= 1'b0;
        ageQ[e]   <= '0;
      end else if (validQ[e]) begin
        ageQ[e]   <= ageQ[e] + age_t'(insAny) - age_t'(olderGone);
      end
    end
  end
endmodule

// File: rtl/rsPool.sv
module rsPool
  import rsPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                insValid,
  output logic                insReady,
  input  logic [OP_W-1:0]     insOp,
  input  logic [TAG_W-1:0]    insDst,
  input  logic                insARdy,
  input  logic [TAG_W-1:0]    insATag,
  input  logic [DATA_W-1:0]   insAVal,
  input  logic                insBRdy,
  input  logic [TAG_W-1:0]    insBTag,
  input  logic [DATA_W-1:0]   insBVal,
  input  logic                cdbValid,
  input  logic [TAG_W-1:0]    cdbTag,
  input  logic [DATA_W-1:0]   cdbVal,
  output logic                dispValid,
  output logic [OP_W-1:0]     dispOp,
  output logic [DATA_W-1:0]   dispA,
  output logic [DATA_W-1:0]   dispB,
  output logic [TAG_W-1:0]    dispDst
);
  ctrlStrobe_t strobes;
  entMask_t    entRdy, validVec;
  entMask_t    insSelW, dispSelW;

  assign insSelW  = strobes.insSel;
  assign dispSelW = strobes.dispSel;

  rsCtrl uCtrl (
    .clk(clk), .rstN(rstN), .insValid(insValid), .entRdy(entRdy),
    .insReady(insReady), .validVec(validVec), .strobes(strobes)
  );

  rsData uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .insOp(insOp), .insDst(insDst),
    .insARdy(insARdy), .insATag(insATag), .insAVal(insAVal),
    .insBRdy(insBRdy), .insBTag(insBTag), .insBVal(insBVal),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbVal(cdbVal),
    .entRdy(entRdy), .dispValid(dispValid), .dispOp(dispOp),
    .dispA(dispA), .dispB(dispB), .dispDst(dispDst)
  );
endmodule

// File: rtl/rsPoolChk.sv
module rsPoolChk
  import rsPkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     insReady,
  input entMask_t validVec,
  input entMask_t insSel,
  input entMask_t dispSel
);
  a_r1_no_insert_when_full: assert property (@(posedge clk) disable iff (!rstN)
    !insReady |-> insSel == '0);

  a_r1_insert_occupies: assert property (@(posedge clk) disable iff (!rstN)
    (insSel != '0) |=> (validVec & $past(insSel)) == $past(insSel));

  a_r5_single_dispatch: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dispSel));

  a_r5_dispatch_occupied: assert property (@(posedge clk) disable iff (!rstN)
    (dispSel != '0) |-> (dispSel & validVec) == dispSel);

  a_r8_freed_after_dispatch: assert property (@(posedge clk) disable iff (!rstN)
    (dispSel != '0) |=> (validVec & $past(dispSel)) == '0);
endmodule

bind rsPool rsPoolChk uChk (
  .clk(clk), .rstN(rstN), .insReady(insReady), .validVec(validVec),
  .insSel(insSelW), .dispSel(dispSelW)
);

// File: tb/tb_rsPool.sv
module tb_rsPool;
  import rsPkg::*;

  localparam int EXP_W = OP_W + 2*DATA_W + TAG_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic insValid = 1'b0, insReady;
  op_t  insOp = '0;
  tag_t insDst = '0, insATag = '0, insBTag = '0;
  logic insARdy = 1'b0, insBRdy = 1'b0;
  data_t insAVal = '0, insBVal = '0;
  logic cdbValid = 1'b0;
  tag_t cdbTag = '0;
  data_t cdbVal = '0;
  logic dispValid;
  op_t  dispOp;
  data_t dispA, dispB;
  tag_t dispDst;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [EXP_W-1:0] expQ[$];
  string reqQ[$];

  always #2 clk = ~clk;

  rsPool dut (
    .clk(clk), .rstN(rstN), .insValid(insValid), .insReady(insReady),
    .insOp(insOp), .insDst(insDst),
    .insARdy(insARdy), .insATag(insATag), .insAVal(insAVal),
    .insBRdy(insBRdy), .insBTag(insBTag), .insBVal(insBVal),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbVal(cdbVal),
    .dispValid(dispValid), .dispOp(dispOp), .dispA(dispA),
    .dispB(dispB), .dispDst(dispDst)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pushExp(input int op, input int a, input int b, input int dst, input string req);
    expQ.push_back({op_t'(op), data_t'(a), data_t'(b), tag_t'(dst)});
    reqQ.push_back(req);
  endtask

  task automatic ins(input int op, input int dst, input bit aR, input int aT, input int aV,
                     input bit bR, input int bT, input int bV);
    insValid = 1'b1; insOp = op_t'(op); insDst = tag_t'(dst);
    insARdy = aR; insATag = tag_t'(aT); insAVal = data_t'(aV);
    insBRdy = bR; insBTag = tag_t'(bT); insBVal = data_t'(bV);
  endtask

  task automatic bcast(input int tag, input int val);
    cdbValid = 1'b1; cdbTag = tag_t'(tag); cdbVal = data_t'(val);
  endtask

  // one clock edge, then drop the one-shot requests; ends at the next negedge
  task automatic step();
    @(posedge clk); #1;
    insValid = 1'b0;
    cdbValid = 1'b0;
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && !done && dispValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5 unexpected dispatch", longint'(dispOp), 0);
      end else begin
        logic [EXP_W-1:0] e;
        string r;
        e = expQ.pop_front();
        r = reqQ.pop_front();
        check({dispOp, dispA, dispB, dispDst} == e, r,
              longint'({dispOp, dispA, dispB, dispDst}), longint'(e));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check(insReady == 1'b1, "R9 insReady", insReady, 1);
    check(dispValid == 1'b0, "R9 dispValid", dispValid, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: both operands ready on entry
    pushExp(1, 16'h10, 16'h20, 1, "R2 direct dispatch");
    ins(1, 1, 1, 0, 16'h10, 1, 0, 16'h20);
    step();
    step();
    check(dispValid == 1'b0, "R8 gone after dispatch", dispValid, 0);

    // R6: younger independent work passes a waiting entry
    ins(2, 2, 0, 5, 0, 1, 0, 16'h7);
    step();
    check(dispValid == 1'b0, "R5 waiting entry held", dispValid, 0);
    pushExp(3, 16'h3, 16'h4, 3, "R6 younger ready first");
    ins(3, 3, 1, 0, 16'h3, 1, 0, 16'h4);
    step();
    cdbValid = 1'b0; cdbTag = 3'd5; cdbVal = 16'h99;
    step();
    check(dispValid == 1'b0, "R3 unqualified tag ignored", dispValid, 0);
    pushExp(2, 16'h55, 16'h7, 2, "R3 capture on broadcast");
    bcast(5, 16'h55);
    step();
    step();

    // R7: two entries woken by one broadcast leave in age order
    ins(4, 4, 0, 1, 0, 1, 0, 16'h1);
    step();
    ins(5, 5, 0, 1, 0, 1, 0, 16'h2);
    step();
    pushExp(4, 16'h11, 16'h1, 4, "R7 older first");
    pushExp(5, 16'h11, 16'h2, 5, "R7 younger second");
    bcast(1, 16'h11);
    step();
    step();
    step();

    // R4: capture in the cycle of insertion
    pushExp(6, 16'h66, 16'h5, 6, "R4 same-cycle capture");
    ins(6, 6, 0, 6, 0, 1, 0, 16'h5);
    bcast(6, 16'h66);
    step();
    step();

    // R1/R8: fill, drop an insert, drain and refill
    for (int k = 0; k < 4; k++) begin
      ins(8 + k, k, 0, 2, 0, 1, 0, 16'h100 + k);
      step();
    end
    check(insReady == 1'b0, "R1 full pool", insReady, 0);
    ins(15, 7, 1, 0, 16'hDEAD, 1, 0, 16'hBEEF);
    step();
    check(dispValid == 1'b0, "R1 dropped insert", dispValid, 0);
    for (int k = 0; k < 4; k++) pushExp(8 + k, 16'h22, 16'h100 + k, k, "R7 drain order");
    pushExp(12, 16'h1, 16'h2, 7, "R8 refill slot");
    bcast(2, 16'h22);
    step();
    check(insReady == 1'b0, "R8 held in dispatch cycle", insReady, 0);
    step();
    check(insReady == 1'b1, "R8 free next cycle", insReady, 1);
    ins(12, 7, 1, 0, 16'h1, 1, 0, 16'h2);
    step();
    repeat (4) step();
    check(expQ.size() == 0, "R5 all expected dispatched", expQ.size(), 0);
    check(dispValid == 1'b0, "R1 dropped insert never dispatched", dispValid, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule